// File: doc/BRIEF.md
# Sample-Driven FM Phase Accumulator

This block is a digitally controlled oscillator for a simple FM transmitter. It runs on a fast clock. On every clock it adds a frequency word to a wrapping phase register. The top bit of that register is a square wave, and it drives the antenna pin directly. The frequency word is a fixed centre value plus the most recent signed 8-bit audio sample. As a result, the output frequency moves linearly around the carrier, by one fixed step for each sample code.

The clock rate, carrier frequency and phase width are build-time parameters, and the centre word is computed from them during elaboration. With the defaults (300 MHz clock, 90 MHz carrier, 19-bit phase), one clock step of fclk/2^19 is about 572 Hz. This is close to the 150 kHz/256 spacing needed to spread the 256 sample codes over a ±75 kHz band. A sample loads on a valid strobe and holds until the next strobe, so a slow serial source (for example 11520 samples per second) can feed the block directly. The full phase register is also brought out so that the oscillator state can be observed.

Top module: `fm_dco`

## Requirements
- R1: `carrier_o` always equals bit ACC_W-1 (bit 18 by default) of `phase_o`.
- R2: After reset is released, `phase_o` grows on every rising clock edge by the current frequency word, modulo 2^ACC_W.
- R3: The frequency word is CENTER plus the held sample sign-extended to ACC_W bits. CENTER = round(CARRIER_HZ·2^ACC_W/CLK_HZ), which is 157286 for the defaults.
- R4: A sample on `sample_i` is taken into the hold register at a rising edge where `sample_vld_i` is 1. From the following edge on, it sets the step size. While `sample_vld_i` is 0, `sample_i` has no effect.
- R5: A rising edge with `rst_n` low clears the phase to 0 and the held sample to 0. After reset, the block therefore steps by exactly CENTER (the unmodulated carrier).
- R6: `sample_i` is read as two's complement (-128 to 127). A negative sample gives a word below CENTER and a lower output frequency than a positive one.
- R7: With a constant sample s, the number of rising edges of `carrier_o` over W clocks is within one of W·(CENTER+s)/2^ACC_W.
- R8: When the sum passes 2^ACC_W, the phase wraps and keeps only the low ACC_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_i | input | 8 | Signed audio sample |
| sample_vld_i | input | 1 | Loads `sample_i` into the hold register |
| carrier_o | output | 1 | Modulated square wave (phase MSB) |
| phase_o | output | 19 | Phase register value |

## Verification
The oscillator is driven with the two extreme samples (-128 and 127), with zero, and with the small values -1 and 1. Each of these is compared cycle by cycle against an independent phase model, so any error in sign extension or in the centre word shows up as a wrong step size. One run pairs a valid strobe with a new sample and then changes `sample_i` while the strobe is low. This separates a correct hold from a design that follows the input. Long windows at -128, 0 and 127 count carrier edges, which confirms that the three frequencies line up with the intended spacing and ordering. A reset in the middle of a run confirms that the block falls back to the unmodulated step.

// File: rtl/fm_pkg.sv
// Package: shared helpers for the FM oscillator.
// Assumes the Hz values fit in 32 bits and that ACC_W is below 31.
package fm_pkg;
    // Rounded phase step that yields carrier_hz at clk_hz with acc_w bits.
    function automatic longint center_word(longint carrier_hz, longint clk_hz, int acc_w);
        longint scaled;
        scaled = carrier_hz * (longint'(1) << acc_w);
        return (scaled + clk_hz / 2) / clk_hz;
    endfunction
endpackage

// File: rtl/fm_sample_hold.sv
// Module: fm_sample_hold
// Holds the latest signed audio sample. It loads on the valid strobe,
// keeps its value otherwise, and clears to zero on reset.
// Assumes the strobe is synchronous to clk.
module fm_sample_hold #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                vld_i,
    output logic [SAMPLE_W-1:0] sample_q
);
    // Capture a new sample on the strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sample_q <= '0;
        else if (vld_i)
            sample_q <= sample_i;
    end

    // R4: without the strobe the held sample does not move
    a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(sample_q));
    // R4: with the strobe the input is taken
    a_r4_load_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> sample_q == $past(sample_i));
endmodule

// File: rtl/fm_freq_word.sv
// Module: fm_freq_word
// Forms the phase increment: the centre word plus the held sample,
// sign-extended to the phase width. This module is purely combinational.
// Assumes ACC_W is larger than SAMPLE_W.
module fm_freq_word #(
    parameter int          ACC_W      = 19,
    parameter int          SAMPLE_W   = 8,
    parameter int unsigned CLK_HZ     = 300_000_000,
    parameter int unsigned CARRIER_HZ = 90_000_000
) (
    input  logic [SAMPLE_W-1:0] sample_q,
    output logic [ACC_W-1:0]    word_o
);
    localparam longint CENTER_L = fm_pkg::center_word(longint'(CARRIER_HZ), longint'(CLK_HZ), ACC_W);
    localparam logic [ACC_W-1:0] CENTER = CENTER_L[ACC_W-1:0];
    localparam int EXT_W = ACC_W - SAMPLE_W;

    logic [ACC_W-1:0] sample_ext;

    // Widen the sample, copying its sign bit.
    always_comb begin
        sample_ext = {{EXT_W{sample_q[SAMPLE_W-1]}}, sample_q};
        word_o     = CENTER + sample_ext;
    end

    // R6: a negative sample puts the word below the centre, a positive one above it
    always_comb begin
        a_r6_sign_side: assert (sample_q[SAMPLE_W-1] ? (word_o < CENTER) : (word_o >= CENTER));
    end
endmodule

// File: rtl/fm_phase_acc.sv
// Module: fm_phase_acc
// Wrapping phase register that advances by word_i on each clock.
// Assumes word_i is settled before the clock edge.
module fm_phase_acc #(
    parameter int ACC_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] word_i,
    output logic [ACC_W-1:0] phase_q
);
    // Advance the phase modulo 2^ACC_W; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else
            phase_q <= phase_q + word_i;
    end
endmodule

// File: rtl/fm_dco.sv
// Module: fm_dco (top)
// Sample-driven FM oscillator: the held sample sets the step size, and
// the MSB of the phase register is the antenna output.
// Assumes a single clock domain and a synchronous, active-low reset.
module fm_dco #(
    parameter int          ACC_W      = 19,
    parameter int          SAMPLE_W   = 8,
    parameter int unsigned CLK_HZ     = 300_000_000,
    parameter int unsigned CARRIER_HZ = 90_000_000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                sample_vld_i,
    output logic                carrier_o,
    output logic [ACC_W-1:0]    phase_o
);
    logic [SAMPLE_W-1:0] held;
    logic [ACC_W-1:0]    word;

    fm_sample_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
        .vld_i(sample_vld_i), .sample_q(held)
    );

    fm_freq_word #(.ACC_W(ACC_W), .SAMPLE_W(SAMPLE_W), .CLK_HZ(CLK_HZ),
                   .CARRIER_HZ(CARRIER_HZ)) u_word (
        .sample_q(held), .word_o(word)
    );

    fm_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .word_i(word), .phase_q(phase_o)
    );

    // Antenna output is the phase MSB.
    always_comb carrier_o = phase_o[ACC_W-1];

    // R2 / R8: each step adds the word from the increment stage, wrapping
    a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> phase_o == ACC_W'($past(phase_o) + $past(word)));
    // R5: reset clears the phase
    a_r5_reset_clear: assert property (@(posedge clk)
        !rst_n |=> phase_o == '0);
endmodule

// File: tb/test_fm_dco.sv
// Directed bench for fm_dco with an independent phase model.
module test_fm_dco;
    localparam int     ACC_W  = 19;
    localparam longint MOD    = longint'(1) << ACC_W;
    // R3: centre step computed from the rounding formula
    localparam longint CENTER = (longint'(90_000_000) * MOD + 150_000_000) / 300_000_000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       sample_i = '0;
    logic             sample_vld_i = 1'b0;
    logic             carrier_o;
    logic [ACC_W-1:0] phase_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    longint    m_acc = 0;
    logic [7:0] m_s  = '0;

    fm_dco i_fm_dco (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
        .sample_vld_i(sample_vld_i), .carrier_o(carrier_o), .phase_o(phase_o)
    );

    always #10 clk = ~clk;

    function automatic longint step_of(logic [7:0] s);
        return CENTER + longint'($signed(s));
    endfunction

    // Reference model, updated at each rising edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_acc <= 0;
            m_s   <= '0;
        end else begin
            m_acc <= (m_acc + step_of(m_s)) % MOD;
            if (sample_vld_i) m_s <= sample_i;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare phase and carrier with the model for n cycles.
    task automatic follow(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(longint'(phase_o) == m_acc, req, longint'(phase_o), m_acc);
            chk(carrier_o == phase_o[ACC_W-1], "R1", longint'(carrier_o), longint'(phase_o[ACC_W-1]));
        end
    endtask

    task automatic load(input logic [7:0] s);
        sample_i     = s;
        sample_vld_i = 1'b1;
        @(negedge clk);
        sample_vld_i = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(phase_o == '0, "R5", longint'(phase_o), 0);
        chk(carrier_o == 1'b0, "R5", longint'(carrier_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(longint'(phase_o) == CENTER, "R5", longint'(phase_o), CENTER);
        chk(longint'(phase_o) == m_acc, "R3", longint'(phase_o), m_acc);
    endtask

    // Varied samples, including extremes and back-to-back strobes.
    task automatic t_patterns;
        logic [7:0] pats [6] = '{8'h80, 8'h7F, 8'h00, 8'hFF, 8'h01, 8'h40};
        foreach (pats[k]) begin
            load(pats[k]);
            follow(5, "R2");
        end
        sample_vld_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            sample_i = 8'(k * 37 + 200);
            @(negedge clk);
        end
        sample_vld_i = 1'b0;
        follow(4, "R3");
    endtask

    // Input changes while the strobe is low must not alter the step.
    task automatic t_hold;
        longint prev;
        load(8'd50);
        @(negedge clk);
        sample_i = 8'h9C;
        prev = longint'(phase_o);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk((longint'(phase_o) - prev + MOD) % MOD == CENTER + 50, "R4",
                (longint'(phase_o) - prev + MOD) % MOD, CENTER + 50);
            prev = longint'(phase_o);
        end
    endtask

    // Find a wrap and confirm only the low bits are kept.
    task automatic t_wrap;
        longint prev;
        bit seen = 0;
        load(8'h7F);
        @(negedge clk);
        prev = longint'(phase_o);
        for (int i = 0; i < 16 && !seen; i++) begin
            @(negedge clk);
            if (longint'(phase_o) < prev) begin
                seen = 1;
                chk(longint'(phase_o) == prev + CENTER + 127 - MOD, "R8",
                    longint'(phase_o), prev + CENTER + 127 - MOD);
            end
            prev = longint'(phase_o);
        end
        chk(seen, "R8", longint'(seen), 1);
    endtask

    // Count carrier rising edges over a window and compare with theory.
    task automatic t_measure(input logic [7:0] s, output int edges);
        localparam int W = 20000;
        longint m, diff;
        logic last;
        load(s);
        @(negedge clk);
        last  = carrier_o;
        edges = 0;
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            if (carrier_o && !last) edges++;
            last = carrier_o;
        end
        m    = step_of(s);
        diff = longint'(edges) * MOD - longint'(W) * m;
        if (diff < 0) diff = -diff;
        chk(diff <= MOD, "R7", longint'(edges), (longint'(W) * m) / MOD);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int e_lo, e_mid, e_hi;
        @(negedge clk); @(negedge clk);
        chk(phase_o == '0, "R5", longint'(phase_o), 0);
        rst_n = 1'b1;
        follow(3, "R2");
        t_patterns();
        t_hold();
        t_wrap();
        t_reset();
        t_measure(8'h80, e_lo);
        t_measure(8'h00, e_mid);
        t_measure(8'h7F, e_hi);
        chk(e_lo < e_hi, "R6", longint'(e_lo), longint'(e_hi));
        chk(e_lo <= e_mid && e_mid <= e_hi, "R6", longint'(e_mid), longint'(e_lo));
        follow(3, "R2");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule